// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the software-visible register file of a DMA controller that runs four or eight channels. A processor reaches it over a plain 32-bit word bus with a write strobe and a combinational read path. Through it software picks each channel's transfer mode and direction, enables the per-channel interrupts, fires channel starts, and reads or acknowledges each channel's completion and error events. It also holds the four descriptor words of every channel and passes them straight to the channel engines.

The channel engines sit outside this block. They report a one-cycle done event, a one-cycle error event and a live two-bit state code per channel. In return they receive the held mode and direction, the descriptor words, and a one-cycle start pulse. A single interrupt line is raised while any channel has an enabled, unacknowledged event. Address bits [1:0] are ignored, so every access is a full aligned word.

Top module: `dmac_regfile`

## Requirements
- R1: After a synchronous active-low reset every register reads zero and the start, mode, direction and interrupt outputs are low.
- R2: Control word 0 at offset 0x00 gives channel ch the nibble at bits [4ch+3:4ch]. Bits [1:0] of the nibble hold the mode (0 off, 1 scatter-gather, 2 one-shot) and bit 2 holds the direction (1 means memory to device). Bit 3 of each nibble reads zero. The held fields drive the mode and direction outputs from the cycle after the write.
- R3: Control word 2 at offset 0x08 holds the interrupt enable of channel ch at bit ch, readable and writable.
- R4: Writing 1 to bit 8+ch of control word 2 while that channel's state input is idle (0) raises the channel's start output for exactly the following cycle, and bit 8+ch reads 1 only during that cycle. If the state is not idle in the write cycle, the request is dropped.
- R5: In status word 0 at offset 0x10, a done event sets bit ch in the next cycle. An error event sets both bit ch and bit 8+ch. Writing 1 to either bit clears it. An event arriving in the same cycle as the clear wins.
- R6: Status word 0 bits [16+2ch+1:16+2ch] return the channel's live state input (0 idle, 1 descriptor fetch, 2 waiting, 3 moving data), and writes to them have no effect.
- R7: The interrupt output is high exactly when some channel has both its event flag (status bit ch) and its enable set.
- R8: Descriptor word w of channel ch sits at offset 0x20 + 16*ch + 4*w, with w = 0 device address, 1 memory address, 2 size, 3 next link. Each word reads back as written and drives its engine output.
- R9: Control word 1 at offset 0x04 holds and returns any written 32-bit value.
- R10: Offsets 0x0C, 0x14, 0x18, 0x1C and everything past the last descriptor read zero, and writes to them change nothing. Bits belonging to channels at or above the channel count read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we_i | input | 1 | Write strobe for the addressed word |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| ev_done_i | input | NUM_CH | Per-channel completion event, one cycle |
| ev_err_i | input | NUM_CH | Per-channel error event, one cycle |
| state_i | input | 2*NUM_CH | Per-channel live engine state |
| start_o | output | NUM_CH | Per-channel one-cycle start pulse |
| mode_o | output | 2*NUM_CH | Per-channel transfer mode |
| dir_o | output | NUM_CH | Per-channel direction, 1 = memory to device |
| irq_o | output | 1 | Combined interrupt |
| desc_dev_o | output | 32*NUM_CH | Device address word per channel |
| desc_mem_o | output | 32*NUM_CH | Memory address word per channel |
| desc_size_o | output | 32*NUM_CH | Size word per channel |
| desc_next_o | output | 32*NUM_CH | Next-link word per channel |

## Verification
The bench goes after three kinds of trouble. The first is a start request made while the channel is busy: a design that fails to gate it would pulse the engine in mid-transfer. The second is a completion event landing in the same cycle software acknowledges the previous one: a design where the clear wins would lose that interrupt for good. The third is a write of ones across the live-state field and the reserved offsets: a design that stores them would read back phantom state or alias into real registers. Random traffic over every offset, with random events and states, compares each read, the interrupt line and every output against a bench model, so that a bit-position slip on the last channel or a descriptor word shows up as a mismatch.

// File: rtl/dmac_regs_pkg.sv
// Shared offsets and codes for the DMA channel register file.
// Assumes a byte-addressed 32-bit word bus.
package dmac_regs_pkg;
    localparam int OFS_CTL0    = 'h00;
    localparam int OFS_CTL1    = 'h04;
    localparam int OFS_CTL2    = 'h08;
    localparam int OFS_STS0    = 'h10;
    localparam int DESC_BASE   = 'h20;
    localparam int DESC_STRIDE = 16;
    localparam int START_LSB   = 8;
    localparam int ERR_LSB     = 8;
    localparam int STATE_LSB   = 16;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_FETCH = 2'd1,
        CH_WAIT  = 2'd2,
        CH_MOVE  = 2'd3
    } ch_state_e;
endpackage

// File: rtl/dmac_chan_ctl.sv
// Control and status flops of one DMA channel: mode, direction, interrupt
// enable, start pulse, event and error flags.
// Assumes the parent decodes the bus and hands over this channel's bits.
module dmac_chan_ctl
    import dmac_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl0_we,
    input  logic [2:0] ctl0_fld,
    input  logic       ctl2_we,
    input  logic       ien_bit,
    input  logic       start_bit,
    input  logic       sts_we,
    input  logic       clr_irq,
    input  logic       clr_err,
    input  logic       ev_done,
    input  logic       ev_err,
    input  logic [1:0] state,
    output logic [1:0] mode,
    output logic       dir,
    output logic       ien,
    output logic       start,
    output logic       irq_flag,
    output logic       err_flag
);
    // Mode and direction follow writes to control word 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= 2'b00;
            dir  <= 1'b0;
        end else if (ctl0_we) begin
            mode <= ctl0_fld[1:0];
            dir  <= ctl0_fld[2];
        end
    end

    // Interrupt enable follows writes to control word 2.
    always_ff @(posedge clk) begin
        if (!rst_n)       ien <= 1'b0;
        else if (ctl2_we) ien <= ien_bit;
    end

    // Start request becomes a one-cycle pulse, only from the idle state.
    always_ff @(posedge clk) begin
        if (!rst_n) start <= 1'b0;
        else        start <= ctl2_we && start_bit && (state == CH_IDLE);
    end

    // Event flags: write-one-to-clear, a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            irq_flag <= (irq_flag && !(sts_we && clr_irq)) || ev_done || ev_err;
            err_flag <= (err_flag && !(sts_we && clr_err)) || ev_err;
        end
    end

    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(ctl2_we && start_bit)); // R4
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(state) == CH_IDLE); // R4
    AST_ERR_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |=> (irq_flag && err_flag)); // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we && clr_irq && !ev_done && !ev_err) |=> !irq_flag); // R5
    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl0_we |=> $stable({dir, mode})); // R2
endmodule

// File: rtl/dmac_desc_bank.sv
// Descriptor storage: four 32-bit words per channel, written from the bus
// and driven continuously to the channel engines.
// Assumes the parent qualifies the write strobe with the address range.
module dmac_desc_bank #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CH_W-1:0]      ch,
    input  logic [1:0]           word,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    output logic [32*NUM_CH-1:0] dev_o,
    output logic [32*NUM_CH-1:0] mem_o,
    output logic [32*NUM_CH-1:0] size_o,
    output logic [32*NUM_CH-1:0] next_o
);
    logic [31:0] slot [NUM_CH][4];

    // Store one descriptor word per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++)
                for (int w = 0; w < 4; w++)
                    slot[c][w] <= '0;
        end else if (we) begin
            slot[ch][word] <= wdata;
        end
    end

    assign rdata = slot[ch][word];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_out
        assign dev_o[32*c +: 32]  = slot[c][0];
        assign mem_o[32*c +: 32]  = slot[c][1];
        assign size_o[32*c +: 32] = slot[c][2];
        assign next_o[32*c +: 32] = slot[c][3];

        AST_DEV_WORD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (we && ch == CH_W'(c) && word == 2'd0) |=> dev_o[32*c +: 32] == $past(wdata)); // R8
        AST_NEXT_WORD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (we && ch == CH_W'(c) && word == 2'd3) |=> next_o[32*c +: 32] == $past(wdata)); // R8
    end
endmodule

// File: rtl/dmac_regfile.sv
// Register file of a four- or eight-channel DMA controller: address decode,
// read multiplexer, per-channel control instances and descriptor storage.
// Assumes full-word accesses; address bits [1:0] are ignored.
module dmac_regfile
    import dmac_regs_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [31:0]          bus_wdata_i,
    output logic [31:0]          bus_rdata_o,
    input  logic [NUM_CH-1:0]    ev_done_i,
    input  logic [NUM_CH-1:0]    ev_err_i,
    input  logic [2*NUM_CH-1:0]  state_i,
    output logic [NUM_CH-1:0]    start_o,
    output logic [2*NUM_CH-1:0]  mode_o,
    output logic [NUM_CH-1:0]    dir_o,
    output logic                 irq_o,
    output logic [32*NUM_CH-1:0] desc_dev_o,
    output logic [32*NUM_CH-1:0] desc_mem_o,
    output logic [32*NUM_CH-1:0] desc_size_o,
    output logic [32*NUM_CH-1:0] desc_next_o
);
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int DESC_END = DESC_BASE + DESC_STRIDE * NUM_CH;

    initial begin
        AST_CH_COUNT: assert (NUM_CH == 4 || NUM_CH == 8); // R10
        AST_MAP_FITS: assert (DESC_END <= (1 << ADDR_W)); // R8
    end

    logic [ADDR_W-1:0] word_addr;
    logic [ADDR_W-1:0] desc_off;
    logic              wr_ctl0, wr_ctl1, wr_ctl2, wr_sts0, in_desc;
    logic [31:0]       ctl1_q;
    logic [31:0]       desc_rdata;
    logic [NUM_CH-1:0] ien_v, irq_v, err_v;
    logic [31:0]       ctl0_rd, ctl2_rd, sts0_rd;

    assign word_addr = {bus_addr_i[ADDR_W-1:2], 2'b00};
    assign wr_ctl0   = bus_we_i && word_addr == ADDR_W'(OFS_CTL0);
    assign wr_ctl1   = bus_we_i && word_addr == ADDR_W'(OFS_CTL1);
    assign wr_ctl2   = bus_we_i && word_addr == ADDR_W'(OFS_CTL2);
    assign wr_sts0   = bus_we_i && word_addr == ADDR_W'(OFS_STS0);
    assign in_desc   = word_addr >= ADDR_W'(DESC_BASE) && word_addr < ADDR_W'(DESC_END);
    assign desc_off  = word_addr - ADDR_W'(DESC_BASE);

    // Control word 1 is a plain held word.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctl1_q <= '0;
        else if (wr_ctl1) ctl1_q <= bus_wdata_i;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dmac_chan_ctl u_ctl (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl0_we   (wr_ctl0),
            .ctl0_fld  (bus_wdata_i[4*c +: 3]),
            .ctl2_we   (wr_ctl2),
            .ien_bit   (bus_wdata_i[c]),
            .start_bit (bus_wdata_i[START_LSB + c]),
            .sts_we    (wr_sts0),
            .clr_irq   (bus_wdata_i[c]),
            .clr_err   (bus_wdata_i[ERR_LSB + c]),
            .ev_done   (ev_done_i[c]),
            .ev_err    (ev_err_i[c]),
            .state     (state_i[2*c +: 2]),
            .mode      (mode_o[2*c +: 2]),
            .dir       (dir_o[c]),
            .ien       (ien_v[c]),
            .start     (start_o[c]),
            .irq_flag  (irq_v[c]),
            .err_flag  (err_v[c])
        );
    end

    dmac_desc_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_desc (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we_i && in_desc),
        .ch     (desc_off[4 +: CH_W]),
        .word   (desc_off[3:2]),
        .wdata  (bus_wdata_i),
        .rdata  (desc_rdata),
        .dev_o  (desc_dev_o),
        .mem_o  (desc_mem_o),
        .size_o (desc_size_o),
        .next_o (desc_next_o)
    );

    // Assemble the packed control and status words from channel bits.
    always_comb begin
        ctl0_rd = '0;
        ctl2_rd = '0;
        sts0_rd = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            ctl0_rd[4*c +: 3]             = {dir_o[c], mode_o[2*c +: 2]};
            ctl2_rd[c]                    = ien_v[c];
            ctl2_rd[START_LSB + c]        = start_o[c];
            sts0_rd[c]                    = irq_v[c];
            sts0_rd[ERR_LSB + c]          = err_v[c];
            sts0_rd[STATE_LSB + 2*c +: 2] = state_i[2*c +: 2];
        end
    end

    // Select the addressed word; unmapped offsets return zero.
    always_comb begin
        if (word_addr == ADDR_W'(OFS_CTL0))      bus_rdata_o = ctl0_rd;
        else if (word_addr == ADDR_W'(OFS_CTL1)) bus_rdata_o = ctl1_q;
        else if (word_addr == ADDR_W'(OFS_CTL2)) bus_rdata_o = ctl2_rd;
        else if (word_addr == ADDR_W'(OFS_STS0)) bus_rdata_o = sts0_rd;
        else if (in_desc)                        bus_rdata_o = desc_rdata;
        else                                     bus_rdata_o = '0;
    end

    assign irq_o = |(irq_v & ien_v);

    AST_IRQ_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_done_i & ien_v) && !wr_ctl2) |=> irq_o); // R7
    AST_NO_START_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctl2 |=> start_o == '0); // R4
endmodule

// File: tb/test_dmac_regfile.sv
`timescale 1ns/1ps
module test_dmac_regfile;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  ev_done = '0, ev_err = '0;
    logic [2*N-1:0] st = '0;
    logic [N-1:0]  start_o, dir_o;
    logic [2*N-1:0] mode_o;
    logic          irq_o;
    logic [32*N-1:0] d_dev, d_mem, d_size, d_next;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [2*N-1:0] m_mode;
    logic [N-1:0]   m_dir, m_ien, m_irq, m_err, m_start;
    logic [31:0]    m_ctl1;
    logic [31:0]    m_desc [4*N];

    always #2 clk = ~clk;

    dmac_regfile #(.NUM_CH(N), .ADDR_W(8)) i_dmac_regfile (
        .clk(clk), .rst_n(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .ev_done_i(ev_done), .ev_err_i(ev_err), .state_i(st),
        .start_o(start_o), .mode_o(mode_o), .dir_o(dir_o), .irq_o(irq_o),
        .desc_dev_o(d_dev), .desc_mem_o(d_mem), .desc_size_o(d_size),
        .desc_next_o(d_next)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [7:0]  wa = {a[7:2], 2'b00};
        logic [31:0] r = '0;
        if (wa == 8'h00) begin
            for (int c = 0; c < N; c++) r[4*c +: 3] = {m_dir[c], m_mode[2*c +: 2]};
        end else if (wa == 8'h04) r = m_ctl1;
        else if (wa == 8'h08) r = {16'h0, m_start, m_ien};
        else if (wa == 8'h10) r = {st, m_err, m_irq};
        else if (wa >= 8'h20 && wa < 8'h20 + 8'(16*N)) r = m_desc[(wa - 8'h20) >> 2];
        return r;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        logic [7:0] wa = {a[7:2], 2'b00};
        if (wa == 8'h00) return "R2";
        if (wa == 8'h04) return "R9";
        if (wa == 8'h08) return "R3 R4";
        if (wa == 8'h10) return "R5 R6";
        if (wa >= 8'h20 && wa < 8'h20 + 8'(16*N)) return "R8";
        return "R10";
    endfunction

    // One bus cycle: drive at the falling edge, check, advance the model.
    task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] wd,
                       input logic [N-1:0] dn, input logic [N-1:0] er,
                       input logic [2*N-1:0] s);
        logic [7:0]   wa;
        logic [N-1:0] nstart;
        bus_we = we; bus_addr = a; bus_wdata = wd;
        ev_done = dn; ev_err = er; st = s;
        #1;
        chk(tag_of(a), bus_rdata, exp_read(a));
        chk("R7", {31'h0, irq_o}, {31'h0, |(m_irq & m_ien)});
        chk("R4", {24'h0, start_o}, {24'h0, m_start});
        chk("R2", {8'h0, dir_o, mode_o}, {8'h0, m_dir, m_mode});
        for (int c = 0; c < N; c++) begin
            chk("R8", d_dev[32*c +: 32],  m_desc[4*c]);
            chk("R8", d_mem[32*c +: 32],  m_desc[4*c+1]);
            chk("R8", d_size[32*c +: 32], m_desc[4*c+2]);
            chk("R8", d_next[32*c +: 32], m_desc[4*c+3]);
        end
        nstart = '0;
        wa = {a[7:2], 2'b00};
        if (we) begin
            if (wa == 8'h00) begin
                for (int c = 0; c < N; c++) begin
                    m_mode[2*c +: 2] = wd[4*c +: 2];
                    m_dir[c] = wd[4*c + 2];
                end
            end else if (wa == 8'h04) m_ctl1 = wd;
            else if (wa == 8'h08) begin
                m_ien = wd[7:0];
                for (int c = 0; c < N; c++) nstart[c] = wd[8+c] && s[2*c +: 2] == 2'd0;
            end else if (wa == 8'h10) begin
                m_irq = m_irq & ~wd[7:0];
                m_err = m_err & ~wd[15:8];
            end else if (wa >= 8'h20 && wa < 8'h20 + 8'(16*N)) m_desc[(wa - 8'h20) >> 2] = wd;
        end
        m_irq = m_irq | dn | er;
        m_err = m_err | er;
        m_start = nstart;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  a;
        logic [2*N-1:0] s;
        void'($urandom(32'h1d0c_5eed));
        m_mode = '0; m_dir = '0; m_ien = '0; m_irq = '0; m_err = '0; m_start = '0; m_ctl1 = '0;
        for (int i = 0; i < 4*N; i++) m_desc[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: every offset and output is zero after reset
        for (int i = 0; i < 64; i++) begin
            bus_addr = 8'(4*i);
            #1 chk("R1", bus_rdata, 32'h0);
        end
        chk("R1", {7'h0, irq_o, start_o, dir_o, mode_o}, 32'h0);
        chk("R1", d_dev[31:0] | d_next[32*N-1 -: 32], 32'h0);

        // R2: mode and direction nibbles, bit 3 of each reads zero
        cyc(1, 8'h00, 32'hFEDC_BA98, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 0, 0);
        // R4: start to busy channel 2 dropped, then accepted when idle
        cyc(1, 8'h08, 32'h0000_04FF, 0, 0, 16'h0030);
        cyc(0, 8'h08, 0, 0, 0, 16'h0030);
        cyc(1, 8'h08, 32'h0000_84FF, 0, 0, 16'h0000);
        cyc(0, 8'h08, 0, 0, 0, 0);
        cyc(0, 8'h08, 0, 0, 0, 0);
        // R5: event on channel 1 then clear racing a new event
        cyc(0, 8'h10, 0, 8'h02, 0, 0);
        cyc(1, 8'h10, 32'h0000_0002, 8'h02, 0, 0);
        cyc(1, 8'h10, 32'h0000_0002, 0, 0, 0);
        // R5, R7: error on channel 7 sets both flags and raises interrupt
        cyc(0, 8'h10, 0, 0, 8'h80, 0);
        cyc(0, 8'h10, 0, 0, 0, 16'hE41B);
        // R6: writing the live state field changes nothing
        cyc(1, 8'h10, 32'hFFFF_0000, 0, 0, 16'h9C63);
        cyc(0, 8'h10, 0, 0, 0, 16'h9C63);
        cyc(1, 8'h10, 32'h0000_8080, 0, 0, 0);
        // R7: interrupt masked when enable cleared
        cyc(1, 8'h08, 32'h0000_00FE, 8'h01, 0, 0);
        cyc(0, 8'h10, 0, 0, 0, 0);
        // R9, R8: held word and first / last descriptor words
        cyc(1, 8'h04, 32'hA5A5_3C3C, 0, 0, 0);
        cyc(1, 8'h20, 32'h1234_5678, 0, 0, 0);
        cyc(1, 8'h9C, 32'h8765_4321, 0, 0, 0);
        cyc(0, 8'h9C, 0, 0, 0, 0);
        // R10: reserved offsets read zero and ignore writes
        cyc(1, 8'h0C, 32'hFFFF_FFFF, 0, 0, 0);
        cyc(1, 8'hA0, 32'hFFFF_FFFF, 0, 0, 0);
        cyc(0, 8'h0C, 0, 0, 0, 0);
        cyc(0, 8'hA0, 0, 0, 0, 0);
        cyc(0, 8'h1C, 0, 0, 0, 0);
        cyc(0, 8'hFD, 0, 0, 0, 0);

        // random traffic over all offsets
        for (int i = 0; i < 3000; i++) begin
            case ($urandom % 4)
                0:       a = 8'(4 * ($urandom % 8));
                1, 2:    a = 8'h20 + 8'(4 * ($urandom % 32));
                default: a = 8'hA0 + 8'(4 * ($urandom % 24));
            endcase
            if ($urandom % 3 == 0) a = 8'h08;
            else if ($urandom % 4 == 0) a = 8'h10;
            a = a | 8'($urandom % 4);
            for (int c = 0; c < N; c++) s[2*c +: 2] = ($urandom % 2) ? 2'd0 : 2'($urandom);
            cyc(($urandom % 2) == 1, a, $urandom,
                8'($urandom & $urandom & $urandom), 8'($urandom & $urandom & $urandom & $urandom), s);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule